// File: doc/BRIEF.md
# Registered Bus Transceiver Lane with Latch and Clock Modes

This block is one direction of a registered bus transceiver. It carries a word made of several 9-bit groups, each holding eight data bits and a parity bit. The storage behind each group can act three ways: as a transparent path, as a level-sensitive latch, or as an edge-triggered register. A latch enable, a capture clock and one active-low capture enable per group select the mode. An active-low output enable gates the whole word. The block has no parity logic of its own. The parity bit of each group is stored and passed like any data bit.

The whole lane runs in one system clock domain. The capture clock is an ordinary input, and the block detects its rising edges by sampling it on the system clock. The latch is built the same way. While the latch enable is high, storage reloads on every system clock edge, and the output takes the live input. The high-impedance state of the pads is shown by a valid flag instead of real tristate drivers. A full two-way transceiver uses two instances, one per direction, each with its own controls. The lane neither accepts nor applies back-pressure: there is no ready signal, and the output reflects the input or the stored value on every cycle.

Top module: `bus_lane_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every group's stored value to zero. After reset, with `lat_en` low and `oe_n` low, `dout` reads all zeros and `dout_valid` is 1.
- R2: While `lat_en` is high, `dout` equals `din` in the same cycle. This holds whatever `cap_clk` and `cap_en_n` are doing.
- R3: A capture edge is a system clock edge at which `cap_clk` is sampled high after being sampled low at the previous edge. At such an edge, with `lat_en` low and `cap_en_n[g]` low, group g stores `din`, and `dout` shows that value from the next cycle.
- R4: While `lat_en` is low and no capture edge occurs, every group keeps its stored value, whatever `din` does.
- R5: Each group has its own capture enable. With `cap_en_n[g]` high, group g keeps its value through a capture edge, while a group whose enable is low loads.
- R6: When `lat_en` goes low, each group keeps the `din` value sampled at the last clock edge at which `lat_en` was high.
- R7: While `oe_n` is high, `dout_valid` is 0 and `dout` is all zeros. Storage keeps working: it still tracks and captures, and the stored value appears once `oe_n` returns low.
- R8: Holding `cap_clk` high over several clock edges captures at most once. A `cap_clk` that is already high when reset is released does not count as a capture edge.
- R9: Group g occupies `din`/`dout` bits [9g+8:9g], and its parity bit is bit 9g+8. The parity bit is stored, captured and gated exactly like the data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_clk | input | 1 | Capture clock, sampled for rising edges |
| lat_en | input | 1 | Latch enable; high makes the lane transparent |
| cap_en_n | input | NGRP | Per-group capture enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | NGRP*(DW+1) | Input word, groups of data plus parity |
| dout | output | NGRP*(DW+1) | Output word, zero while disabled |
| dout_valid | output | 1 | High when outputs are driven, low for high impedance |

## Verification
The bench targets three kinds of corner case. The first is a `cap_clk` already high at reset release, or held high across many cycles. A design that levels instead of detecting edges would keep reloading and lose the captured word. The second is the falling edge of `lat_en`, where a design off by one cycle would keep the input from the cycle after the latch closed. The third is a capture edge with one group's enable high: shared gating would overwrite the disabled group. The bench also changes storage while the outputs are disabled, and a parity-only pattern shows any design that drops or shifts the top bit of a group.

// File: rtl/bus_lane_pkg.sv
package bus_lane_pkg;
  // Source of a group's next stored value.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_LIVE = 2'd1,
    SRC_EDGE = 2'd2
  } upd_src_e;
endpackage

// File: rtl/bus_lane_edge.sv
module bus_lane_edge (
  input  logic clk,
  input  logic rst,
  input  logic cap_clk,
  output logic rise
);
  // Previous sample resets high so an already-high clock is not an edge.
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= cap_clk;
  end

  assign rise = cap_clk & ~prev_q;
endmodule

// File: rtl/bus_lane_cell.sv
module bus_lane_cell #(
  parameter int GW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_en,
  input  logic          rise,
  input  logic          cap_en_n,
  input  logic [GW-1:0] din,
  output logic [GW-1:0] dout
);
  import bus_lane_pkg::*;

  logic [GW-1:0] store_q;
  upd_src_e      src;

  always_comb begin
    if (lat_en)                  src = SRC_LIVE;
    else if (rise && !cap_en_n)  src = SRC_EDGE;
    else                         src = SRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else begin
      case (src)
        SRC_LIVE, SRC_EDGE: store_q <= din;
        default:            store_q <= store_q;
      endcase
    end
  end

  // Transparent while latch enable is high, stored value otherwise.
  assign dout = lat_en ? din : store_q;
endmodule

// File: rtl/bus_lane_gate.sv
module bus_lane_gate #(
  parameter int W = 18
) (
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_valid
);
  assign dout_valid = ~oe_n;
  assign dout       = oe_n ? '0 : din;
endmodule

// File: rtl/bus_lane_reg.sv
module bus_lane_reg #(
  parameter int NGRP = 2,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_clk,
  input  logic                     lat_en,
  input  logic [NGRP-1:0]          cap_en_n,
  input  logic                     oe_n,
  input  logic [NGRP*(DW+1)-1:0]   din,
  output logic [NGRP*(DW+1)-1:0]   dout,
  output logic                     dout_valid
);
  localparam int GW = DW + 1;
  localparam int W  = NGRP * GW;

  logic         rise;
  logic [W-1:0] held;

  bus_lane_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .cap_clk (cap_clk),
    .rise    (rise)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    bus_lane_cell #(.GW(GW)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .lat_en   (lat_en),
      .rise     (rise),
      .cap_en_n (cap_en_n[g]),
      .din      (din[g*GW +: GW]),
      .dout     (held[g*GW +: GW])
    );
  end

  bus_lane_gate #(.W(W)) u_gate (
    .oe_n       (oe_n),
    .din        (held),
    .dout       (dout),
    .dout_valid (dout_valid)
  );
endmodule

// File: rtl/bus_lane_reg_chk.sv
module bus_lane_reg_chk #(
  parameter int NGRP = 2,
  parameter int DW   = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cap_clk,
  input logic                   lat_en,
  input logic [NGRP-1:0]        cap_en_n,
  input logic                   oe_n,
  input logic [NGRP*(DW+1)-1:0] din,
  input logic [NGRP*(DW+1)-1:0] dout,
  input logic                   dout_valid
);
  localparam int GW = DW + 1;

  p_transparent_r2: assert property (@(posedge clk) disable iff (rst)
    (lat_en && !oe_n) |-> (dout == din));

  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!dout_valid && dout == '0));

  p_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> dout_valid);

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R4 / R5: no load when the group's enable was high and latch was closed
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !lat_en && $past(!lat_en) && $past(cap_en_n[g])
       && !oe_n && $past(!oe_n))
      |-> (dout[g*GW +: GW] == $past(dout[g*GW +: GW])));

    // R3: a capture edge with enable low loads the sampled input
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!rst, 2) && $past(!lat_en) && $past(!cap_en_n[g])
       && $past(cap_clk) && !$past(cap_clk, 2) && !lat_en && !oe_n)
      |-> (dout[g*GW +: GW] == $past(din[g*GW +: GW])));
  end
endmodule

bind bus_lane_reg bus_lane_reg_chk #(.NGRP(NGRP), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cap_clk    (cap_clk),
  .lat_en     (lat_en),
  .cap_en_n   (cap_en_n),
  .oe_n       (oe_n),
  .din        (din),
  .dout       (dout),
  .dout_valid (dout_valid)
);

// File: tb/sim_bus_lane_reg.sv
module sim_bus_lane_reg;
  localparam int NG = 2;
  localparam int DW = 8;
  localparam int GW = DW + 1;
  localparam int W  = NG * GW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cap_clk = 1'b1;
  logic          lat_en = 1'b0;
  logic [NG-1:0] cap_en_n = '1;
  logic          oe_n = 1'b0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout;
  logic          dout_valid;

  int errors = 0;
  int checks = 0;

  logic [GW-1:0] m_store [NG];
  logic          m_prev;

  always #5 clk = ~clk;

  bus_lane_reg #(.NGRP(NG), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cap_clk(cap_clk), .lat_en(lat_en),
    .cap_en_n(cap_en_n), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_valid(dout_valid)
  );

  function automatic logic [W-1:0] exp_out();
    logic [W-1:0] r;
    for (int g = 0; g < NG; g++)
      r[g*GW +: GW] = lat_en ? din[g*GW +: GW] : m_store[g];
    return oe_n ? '0 : r;
  endfunction

  function automatic void model_edge();
    logic rise;
    rise = cap_clk && !m_prev;
    for (int g = 0; g < NG; g++) begin
      if (rst)                          m_store[g] = '0;
      else if (lat_en)                  m_store[g] = din[g*GW +: GW];
      else if (rise && !cap_en_n[g])    m_store[g] = din[g*GW +: GW];
    end
    m_prev = rst ? 1'b1 : cap_clk;
  endfunction

  task automatic step(input string tag);
    logic [W-1:0] e;
    @(posedge clk);
    model_edge();
    #1;
    e = exp_out();
    checks++;
    if (dout !== e || dout_valid !== !oe_n) begin
      errors++;
      $display("FAIL %s: dout=%h valid=%b expected dout=%h valid=%b",
               tag, dout, dout_valid, e, !oe_n);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int g = 0; g < NG; g++) m_store[g] = '0;
    m_prev = 1'b1;
    din = W'($urandom);
    // R1: reset clears storage
    step("R1"); step("R1");
    rst = 0;
    step("R1");
    // R8: clock already high after reset is not an edge
    cap_en_n = '0; din = W'($urandom);
    step("R8"); step("R8");
    // R2: transparent, clock activity ignored
    lat_en = 1; din = W'($urandom); cap_clk = 0;
    step("R2");
    din = W'($urandom); cap_clk = 1; cap_en_n = '1;
    step("R2");
    // R6: latch closes, keeps last sampled value
    lat_en = 0; din = W'($urandom); cap_clk = 0;
    step("R6"); step("R6");
    // R3: capture edge
    din = W'($urandom); cap_en_n = '0; cap_clk = 1;
    step("R3");
    // R8 / R4: clock held high, data moves
    din = W'($urandom);
    step("R8"); din = W'($urandom); step("R4");
    // R5: group 1 disabled, group 0 loads
    cap_clk = 0; step("R4");
    cap_en_n = 2'b10; cap_clk = 1; din = W'($urandom);
    step("R5");
    // R9: parity-only pattern
    cap_clk = 0; step("R4");
    cap_en_n = '0; cap_clk = 1; din = '0;
    for (int g = 0; g < NG; g++) din[g*GW + DW] = 1'b1;
    step("R9");
    // R7: disabled outputs, storage keeps tracking
    oe_n = 1; step("R7");
    lat_en = 1; din = W'($urandom); step("R7");
    lat_en = 0; din = W'($urandom); step("R7");
    oe_n = 0; step("R7");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      string tag;
      cap_clk  = 1'($urandom);
      lat_en   = ($urandom % 4) == 0;
      cap_en_n = NG'($urandom);
      oe_n     = ($urandom % 8) == 0;
      din      = W'($urandom);
      if (($urandom % 200) == 0) rst = 1; else rst = 0;
      if (rst)          tag = "R1";
      else if (oe_n)    tag = "R7";
      else if (lat_en)  tag = "R2";
      else if (cap_clk && !m_prev) tag = "R3";
      else              tag = "R4";
      step(tag);
    end
    rst = 0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule